// File: doc/BRIEF.md
# Command-Queue Decoder and Validator

This block sits between a translation-unit command queue and the engines that carry out its commands. It accepts one decoded command at a time over a valid/ready handshake and checks that the opcode is one the unit implements. It sorts each command into a dispatch class, splits the shared configuration-invalidate opcode into a global form and a stream-range form, and enforces the secure-domain rule of the queue it serves. Each legal command leaves the block as a single-cycle dispatch strobe. The strobe carries the class, the opcode, the stream identifier, a stream-match mask, the decoded resume outcome and the completion-signal kind of a barrier.

When a command breaks a rule, no dispatch is made. The block emits a one-cycle error pulse with a code and the security state of the issuing queue. It then raises a global queue-error flag and stops accepting commands until software pulses a clear input. The code stays visible in a sticky status output until that clear.

Top module: `cmdq_decoder`

## Requirements
- R1: An accepted command with a legal opcode produces exactly one disp_valid pulse, in the cycle after the handshake. The legal opcodes are 0x01-0x07, 0x10-0x13, 0x18, 0x1A, 0x20-0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44-0x46, 0x50-0x53, 0x58, 0x5A, 0x60, 0x70 and 0x73.
- R2: An accepted command with any other opcode dispatches nothing. It pulses err_pulse with err_code 1.
- R3: Opcode 0x04 with cmd_range 31 dispatches class 4 (global config invalidate) with disp_sid_mask all zeros. With cmd_range r below 31 it dispatches class 3 (stream-range invalidate) with disp_sid_mask bits above r set and bits 0..r clear. A stream s is then hit exactly when (s >> (r+1)) equals (cmd_sid >> (r+1)).
- R4: On a non-secure queue (q_secure 0), cmd_ssec 1 is an error with err_code 2 and no dispatch for every command that names a stream. These are opcodes 0x01-0x03 and 0x05-0x07, 0x04 with range below 31, and 0x40, 0x41, 0x44 and 0x45. For other commands, or on a secure queue, the bit has no effect.
- R5: err_secure, valid with err_pulse, equals the q_secure value in effect when the failing command was accepted.
- R6: After err_pulse, cmd_ready stays 0, gerr_flag stays 1 and err_status keeps the code until err_clear is pulsed. Ready returns in the cycle after the clear.
- R7: For opcode 0x46, disp_sig passes the 2-bit signal field: 0 for none, 1 for an interrupt/MSI write, 2 for an event broadcast. The value 3 is an error with err_code 3. For every other class disp_sig is 0.
- R8: For opcode 0x44, disp_resume is 1 (retry) when cmd_act is 1, 2 (bus error) when cmd_act is 0 and cmd_abt is 1, and 3 (silent terminate) when both are 0. For every other class it is 0.
- R9: disp_class encodes 1 prefetch (0x01-0x02), 2 single stream entry (0x03), 5 context descriptor (0x05-0x07), 6 TLB invalidate (0x10-0x60 group), 7 dirty-tracking (0x70, 0x73), 8 ATC (0x40), 9 page response (0x41), 10 resume (0x44), 11 stall terminate (0x45) and 12 barrier (0x46).
- R10: cmd_ready is high only when disp_ready is high and the block is not stalled. While disp_ready is low, no command is taken and nothing is dispatched.
- R11: After reset, disp_valid, err_pulse, gerr_flag and err_status are 0, and cmd_ready follows disp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| q_secure | input | 1 | Security state of the queue feeding the block |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 8 | Opcode |
| cmd_sid | input | SID_W | Stream identifier |
| cmd_range | input | 5 | Range field of opcode 0x04 |
| cmd_ssec | input | 1 | Secure-domain bit of the stream |
| cmd_sig | input | 2 | Barrier completion-signal field |
| cmd_act | input | 1 | Resume action bit |
| cmd_abt | input | 1 | Resume abort bit |
| disp_ready | input | 1 | Downstream can take a dispatch |
| disp_valid | output | 1 | Single-cycle dispatch strobe |
| disp_class | output | 4 | Dispatch class |
| disp_op | output | 8 | Dispatched opcode |
| disp_sid | output | SID_W | Dispatched stream identifier |
| disp_sid_mask | output | SID_W | Stream bits that must match |
| disp_resume | output | 2 | Resume outcome |
| disp_sig | output | 2 | Completion-signal kind |
| err_clear | input | 1 | Software clear of the stall |
| err_pulse | output | 1 | Single-cycle error strobe |
| err_code | output | 3 | Error code during err_pulse |
| err_secure | output | 1 | Queue security state of the failed command |
| gerr_flag | output | 1 | Global queue-error flag |
| err_status | output | 3 | Sticky error code |

## Verification
Every result is registered once. Dispatch and error outputs therefore show up one clock edge after the edge where cmd_valid and cmd_ready are both high. The bench drives inputs on the falling edge and samples at the next falling edge, which falls inside that result cycle. The stall, flag and status are checked in that same cycle and again a few cycles later to prove they hold. Ready is expected back one edge after the clear pulse, and backpressure is checked cycle by cycle while disp_ready is low. It is then checked one cycle after disp_ready rises, and once more to confirm the strobe is a single pulse.

// File: rtl/cmdq_dec_pkg.sv
package cmdq_dec_pkg;

    typedef enum logic [3:0] {
        CL_NONE       = 4'd0,
        CL_PREFETCH   = 4'd1,
        CL_STE        = 4'd2,
        CL_STE_RANGE  = 4'd3,
        CL_CFG_ALL    = 4'd4,
        CL_CD         = 4'd5,
        CL_TLBI       = 4'd6,
        CL_DIRTY      = 4'd7,
        CL_ATC        = 4'd8,
        CL_PAGE_RESP  = 4'd9,
        CL_RESUME     = 4'd10,
        CL_STALL_TERM = 4'd11,
        CL_BARRIER    = 4'd12
    } cmd_class_e;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_RETRY  = 2'd1,
        RK_BUSERR = 2'd2,
        RK_SILENT = 2'd3
    } resume_kind_e;

    typedef enum logic [2:0] {
        EC_NONE       = 3'd0,
        EC_BAD_OP     = 3'd1,
        EC_SEC_DOMAIN = 3'd2,
        EC_BAD_SIGNAL = 3'd3
    } err_code_e;

    localparam int unsigned RANGE_W   = 5;
    localparam logic [RANGE_W-1:0] RANGE_GLOBAL = 5'd31;
    localparam logic [1:0] SIG_RESERVED = 2'b11;

endpackage

// File: rtl/cmdq_dec_classify.sv
module cmdq_dec_classify
    import cmdq_dec_pkg::*;
#(
    parameter int unsigned OP_W = 8
) (
    input  logic [OP_W-1:0]    op,
    input  logic [RANGE_W-1:0] range_f,
    output logic               legal,
    output cmd_class_e         cls,
    output logic               names_stream
);

    always_comb begin
        legal        = 1'b1;
        cls          = CL_NONE;
        names_stream = 1'b0;
        case (op)
            8'h01, 8'h02: begin
                cls          = CL_PREFETCH;
                names_stream = 1'b1;
            end
            8'h03: begin
                cls          = CL_STE;
                names_stream = 1'b1;
            end
            8'h04: begin
                if (range_f == RANGE_GLOBAL) begin
                    cls = CL_CFG_ALL;
                end else begin
                    cls          = CL_STE_RANGE;
                    names_stream = 1'b1;
                end
            end
            8'h05, 8'h06, 8'h07: begin
                cls          = CL_CD;
                names_stream = 1'b1;
            end
            8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
            8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
            8'h50, 8'h51, 8'h52, 8'h53, 8'h58, 8'h5A, 8'h60: begin
                cls = CL_TLBI;
            end
            8'h70, 8'h73: cls = CL_DIRTY;
            8'h40: begin
                cls          = CL_ATC;
                names_stream = 1'b1;
            end
            8'h41: begin
                cls          = CL_PAGE_RESP;
                names_stream = 1'b1;
            end
            8'h44: begin
                cls          = CL_RESUME;
                names_stream = 1'b1;
            end
            8'h45: begin
                cls          = CL_STALL_TERM;
                names_stream = 1'b1;
            end
            8'h46: cls = CL_BARRIER;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmdq_dec_fields.sv
module cmdq_dec_fields
    import cmdq_dec_pkg::*;
#(
    parameter int unsigned SID_W = 32
) (
    input  cmd_class_e         cls,
    input  logic [RANGE_W-1:0] range_f,
    input  logic [1:0]         sig_f,
    input  logic               act_f,
    input  logic               abt_f,
    output logic [SID_W-1:0]   sid_mask,
    output resume_kind_e       rkind,
    output logic [1:0]         sig_kind,
    output logic               sig_bad
);

    logic [SID_W-1:0] range_mask;

    // Bits strictly above the range field take part in the stream match.
    always_comb begin
        for (int i = 0; i < SID_W; i++) begin
            range_mask[i] = (i > int'(range_f));
        end
    end

    always_comb begin
        case (cls)
            CL_STE_RANGE: sid_mask = range_mask;
            CL_PREFETCH, CL_STE, CL_CD, CL_ATC, CL_PAGE_RESP,
            CL_RESUME, CL_STALL_TERM: sid_mask = '1;
            default: sid_mask = '0;
        endcase
    end

    always_comb begin
        rkind = RK_NONE;
        if (cls == CL_RESUME) begin
            if (act_f)      rkind = RK_RETRY;
            else if (abt_f) rkind = RK_BUSERR;
            else            rkind = RK_SILENT;
        end
    end

    always_comb begin
        sig_kind = 2'b00;
        sig_bad  = 1'b0;
        if (cls == CL_BARRIER) begin
            sig_kind = sig_f;
            sig_bad  = (sig_f == SIG_RESERVED);
        end
    end

endmodule

// File: rtl/cmdq_decoder.sv
module cmdq_decoder
    import cmdq_dec_pkg::*;
#(
    parameter int unsigned SID_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_secure,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [7:0]       cmd_op,
    input  logic [SID_W-1:0] cmd_sid,
    input  logic [4:0]       cmd_range,
    input  logic             cmd_ssec,
    input  logic [1:0]       cmd_sig,
    input  logic             cmd_act,
    input  logic             cmd_abt,
    input  logic             disp_ready,
    output logic             disp_valid,
    output logic [3:0]       disp_class,
    output logic [7:0]       disp_op,
    output logic [SID_W-1:0] disp_sid,
    output logic [SID_W-1:0] disp_sid_mask,
    output logic [1:0]       disp_resume,
    output logic [1:0]       disp_sig,
    input  logic             err_clear,
    output logic             err_pulse,
    output logic [2:0]       err_code,
    output logic             err_secure,
    output logic             gerr_flag,
    output logic [2:0]       err_status
);

    typedef struct packed {
        logic             dv;
        cmd_class_e       cls;
        logic [7:0]       op;
        logic [SID_W-1:0] sid;
        logic [SID_W-1:0] mask;
        resume_kind_e     rk;
        logic [1:0]       sig;
        logic             ep;
        err_code_e        ec;
        logic             esec;
        logic             stall;
        err_code_e        stat;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic             op_legal;
    cmd_class_e       op_cls;
    logic             op_names_stream;
    logic [SID_W-1:0] f_mask;
    resume_kind_e     f_rk;
    logic [1:0]       f_sig;
    logic             f_sig_bad;

    cmdq_dec_classify #(.OP_W(8)) u_classify (
        .op           (cmd_op),
        .range_f      (cmd_range),
        .legal        (op_legal),
        .cls          (op_cls),
        .names_stream (op_names_stream)
    );

    cmdq_dec_fields #(.SID_W(SID_W)) u_fields (
        .cls      (op_cls),
        .range_f  (cmd_range),
        .sig_f    (cmd_sig),
        .act_f    (cmd_act),
        .abt_f    (cmd_abt),
        .sid_mask (f_mask),
        .rkind    (f_rk),
        .sig_kind (f_sig),
        .sig_bad  (f_sig_bad)
    );

    assign cmd_ready = disp_ready && !st_q.stall;

    always_comb begin
        err_code_e verdict;
        st_d    = st_q;
        st_d.dv = 1'b0;
        st_d.ep = 1'b0;
        st_d.ec = EC_NONE;
        verdict = EC_NONE;

        if (err_clear) begin
            st_d.stall = 1'b0;
            st_d.stat  = EC_NONE;
        end

        if (cmd_valid && cmd_ready) begin
            if (!op_legal)
                verdict = EC_BAD_OP;
            else if (!q_secure && cmd_ssec && op_names_stream)
                verdict = EC_SEC_DOMAIN;
            else if (f_sig_bad)
                verdict = EC_BAD_SIGNAL;

            if (verdict == EC_NONE) begin
                st_d.dv   = 1'b1;
                st_d.cls  = op_cls;
                st_d.op   = cmd_op;
                st_d.sid  = cmd_sid;
                st_d.mask = f_mask;
                st_d.rk   = f_rk;
                st_d.sig  = f_sig;
            end else begin
                st_d.ep    = 1'b1;
                st_d.ec    = verdict;
                st_d.esec  = q_secure;
                st_d.stall = 1'b1;
                st_d.stat  = verdict;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_valid    = st_q.dv;
    assign disp_class    = st_q.cls;
    assign disp_op       = st_q.op;
    assign disp_sid      = st_q.sid;
    assign disp_sid_mask = st_q.mask;
    assign disp_resume   = st_q.rk;
    assign disp_sig      = st_q.sig;
    assign err_pulse     = st_q.ep;
    assign err_code      = st_q.ec;
    assign err_secure    = st_q.esec;
    assign gerr_flag     = st_q.stall;
    assign err_status    = st_q.stat;

    // R10
    disp_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> $past(cmd_valid && cmd_ready));

    // R1
    disp_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_valid && err_pulse));

    // R2
    err_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_code != 3'd0 && err_status == err_code));

    // R6
    err_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!cmd_ready && gerr_flag));

    // R6
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_clear) && $past(gerr_flag)) |-> !gerr_flag);

    // R3
    global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_class == 4'd4) |-> (disp_sid_mask == '0));

endmodule

// File: tb/sim_cmdq_decoder.sv
module sim_cmdq_decoder;

    localparam int SID_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             q_secure = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [7:0]       cmd_op = '0;
    logic [SID_W-1:0] cmd_sid = '0;
    logic [4:0]       cmd_range = 5'd31;
    logic             cmd_ssec = 1'b0;
    logic [1:0]       cmd_sig = '0;
    logic             cmd_act = 1'b0;
    logic             cmd_abt = 1'b0;
    logic             disp_ready = 1'b1;
    logic             disp_valid;
    logic [3:0]       disp_class;
    logic [7:0]       disp_op;
    logic [SID_W-1:0] disp_sid;
    logic [SID_W-1:0] disp_sid_mask;
    logic [1:0]       disp_resume;
    logic [1:0]       disp_sig;
    logic             err_clear = 1'b0;
    logic             err_pulse;
    logic [2:0]       err_code;
    logic             err_secure;
    logic             gerr_flag;
    logic [2:0]       err_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmdq_decoder #(.SID_W(SID_W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    function automatic bit op_is_legal(input logic [7:0] op);
        case (op)
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
            8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
            8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
            8'h40, 8'h41, 8'h44, 8'h45, 8'h46,
            8'h50, 8'h51, 8'h52, 8'h53, 8'h58, 8'h5A, 8'h60,
            8'h70, 8'h73: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Drive one command at a falling edge; return at the next falling edge,
    // which lies in the cycle that shows the registered result.
    task automatic issue(input logic [7:0] op, input logic [31:0] sid, input logic [4:0] rng,
                         input logic ss, input logic [1:0] sg, input logic ac, input logic ab);
        @(negedge clk);
        cmd_op = op; cmd_sid = sid; cmd_range = rng; cmd_ssec = ss;
        cmd_sig = sg; cmd_act = ac; cmd_abt = ab; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R11 disp_valid", disp_valid, 0);
        chk_eq("R11 err_pulse", err_pulse, 0);
        chk_eq("R11 gerr_flag", gerr_flag, 0);
        chk_eq("R11 err_status", err_status, 0);
        chk_eq("R11 cmd_ready", cmd_ready, 1);
    endtask

    task automatic t_opcode_sweep();
        q_secure = 1'b1;
        for (int op = 0; op < 256; op++) begin
            bit lg;
            lg = op_is_legal(op[7:0]);
            issue(op[7:0], 32'h0, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
            if (lg) begin
                chk_eq("R1 legal dispatch", disp_valid, 1);
                chk_eq("R1 disp_op", disp_op, op);
                chk_eq("R1 no error", err_pulse, 0);
                @(negedge clk);
                chk_eq("R1 single strobe", disp_valid, 0);
            end else begin
                chk_eq("R2 no dispatch", disp_valid, 0);
                chk_eq("R2 err_pulse", err_pulse, 1);
                chk_eq("R2 err_code", err_code, 1);
                chk_eq("R6 ready low", cmd_ready, 0);
                clear_err();
                chk_eq("R6 ready back", cmd_ready, 1);
            end
        end
    endtask

    task automatic t_classes();
        logic [7:0] ops [10] = '{8'h01, 8'h03, 8'h06, 8'h12, 8'h5A, 8'h70, 8'h40, 8'h41, 8'h45, 8'h46};
        logic [3:0] cls [10] = '{4'd1, 4'd2, 4'd5, 4'd6, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd12};
        q_secure = 1'b0;
        for (int i = 0; i < 10; i++) begin
            issue(ops[i], 32'h55, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
            chk_eq("R9 class", disp_class, cls[i]);
            chk_eq("R8 resume none", disp_resume, 0);
        end
        issue(8'h03, 32'hABCD, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
        chk_eq("R9 sid passed", disp_sid, 32'hABCD);
        chk_eq("R9 exact mask", disp_sid_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_range_split();
        logic [4:0] rngs [4] = '{5'd0, 5'd7, 5'd15, 5'd30};
        logic [31:0] cmd_s = 32'h1234_5678;
        q_secure = 1'b0;
        issue(8'h04, cmd_s, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
        chk_eq("R3 global class", disp_class, 4);
        chk_eq("R3 global mask", disp_sid_mask, 0);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] expm;
            expm = ~((64'd1 << (rngs[i] + 1)) - 64'd1);
            issue(8'h04, cmd_s, rngs[i], 1'b0, 2'b00, 1'b0, 1'b0);
            chk_eq("R3 range class", disp_class, 3);
            chk_eq("R3 range mask", disp_sid_mask, expm[31:0]);
            for (int k = 0; k < 3; k++) begin
                logic [31:0] s;
                bit want, got;
                s = (k == 0) ? cmd_s ^ 32'h1 : (k == 1) ? cmd_s ^ (32'h1 << (rngs[i] + 1)) : 32'hFFFF_0000;
                want = ((s >> (rngs[i] + 1)) == (cmd_s >> (rngs[i] + 1)));
                got  = ((s & disp_sid_mask) == (disp_sid & disp_sid_mask));
                chk_eq("R3 stream match rule", got, want);
            end
        end
    endtask

    task automatic t_secure_domain();
        q_secure = 1'b0;
        issue(8'h03, 32'h9, 5'd31, 1'b1, 2'b00, 1'b0, 1'b0);
        chk_eq("R4 no dispatch", disp_valid, 0);
        chk_eq("R4 err_code", err_code, 2);
        chk_eq("R5 err_secure ns", err_secure, 0);
        repeat (4) @(negedge clk);
        chk_eq("R6 still stalled ready", cmd_ready, 0);
        chk_eq("R6 flag held", gerr_flag, 1);
        chk_eq("R6 status held", err_status, 2);
        issue(8'h10, 32'h0, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
        chk_eq("R6 stalled no dispatch", disp_valid, 0);
        clear_err();
        chk_eq("R6 flag cleared", gerr_flag, 0);
        chk_eq("R6 status cleared", err_status, 0);
        chk_eq("R6 ready restored", cmd_ready, 1);
        issue(8'h04, 32'h9, 5'd3, 1'b1, 2'b00, 1'b0, 1'b0);
        chk_eq("R4 range form checked", err_code, 2);
        clear_err();
        issue(8'h04, 32'h9, 5'd31, 1'b1, 2'b00, 1'b0, 1'b0);
        chk_eq("R4 global form unaffected", disp_valid, 1);
        issue(8'h10, 32'h9, 5'd31, 1'b1, 2'b00, 1'b0, 1'b0);
        chk_eq("R4 no-stream op unaffected", disp_valid, 1);
        q_secure = 1'b1;
        issue(8'h44, 32'h9, 5'd31, 1'b1, 2'b00, 1'b1, 1'b0);
        chk_eq("R4 secure queue allows", disp_valid, 1);
        issue(8'h00, 32'h0, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
        chk_eq("R5 err_secure s", err_secure, 1);
        chk_eq("R2 bad op on secure", err_code, 1);
        clear_err();
    endtask

    task automatic t_barrier_signal();
        q_secure = 1'b0;
        for (int s = 0; s < 3; s++) begin
            issue(8'h46, 32'h0, 5'd31, 1'b0, s[1:0], 1'b0, 1'b0);
            chk_eq("R7 signal kind", disp_sig, s);
        end
        issue(8'h10, 32'h0, 5'd31, 1'b0, 2'b10, 1'b0, 1'b0);
        chk_eq("R7 non-barrier sig zero", disp_sig, 0);
        issue(8'h46, 32'h0, 5'd31, 1'b0, 2'b11, 1'b0, 1'b0);
        chk_eq("R7 reserved no dispatch", disp_valid, 0);
        chk_eq("R7 reserved err_code", err_code, 3);
        clear_err();
    endtask

    task automatic t_resume();
        q_secure = 1'b0;
        issue(8'h44, 32'h1, 5'd31, 1'b0, 2'b00, 1'b1, 1'b1);
        chk_eq("R8 retry", disp_resume, 1);
        issue(8'h44, 32'h1, 5'd31, 1'b0, 2'b00, 1'b0, 1'b1);
        chk_eq("R8 bus error", disp_resume, 2);
        issue(8'h44, 32'h1, 5'd31, 1'b0, 2'b00, 1'b0, 1'b0);
        chk_eq("R8 silent", disp_resume, 3);
        issue(8'h45, 32'h1, 5'd31, 1'b0, 2'b00, 1'b1, 1'b1);
        chk_eq("R8 stall-term none", disp_resume, 0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        disp_ready = 1'b0;
        cmd_op = 8'h11; cmd_ssec = 1'b0; cmd_sig = 2'b00; cmd_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_eq("R10 ready low", cmd_ready, 0);
            chk_eq("R10 no dispatch", disp_valid, 0);
        end
        disp_ready = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_eq("R10 dispatch after ready", disp_valid, 1);
        chk_eq("R10 op", disp_op, 8'h11);
        @(negedge clk);
        chk_eq("R1 one strobe", disp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_opcode_sweep();
        t_classes();
        t_range_split();
        t_secure_domain();
        t_barrier_signal();
        t_resume();
        t_backpressure();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule